// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on a received Ethernet byte stream and decides, from the destination address, whether each frame is passed, removed, or passed with an abort mark on its last byte. It captures the first six bytes of a frame and classifies the frame as broadcast, multicast or unicast. It then compares the address with a programmed group address or with the station's own address, according to three enable bits in a control register. Frames that carry a VLAN tag are never rejected on their unicast address.

A rejected frame is handled according to its length. The whole frame is held in an internal store until its end is seen. A rejected frame of standard size is removed from the stream when the drop-enable input is high, and a saturating counter records it. When drop-enable is low, the frame is forwarded instead, with the abort mark set on its last byte. A frame longer than the standard maximum cannot be held whole. It starts to leave the store as soon as it passes that length, so it is never removed and never counted. If it is rejected, it ends with the abort mark. Software programs the addresses and the control bits and reads the removed-frame count through a simple register port. Reading the count clears it.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset the control bits, both addresses and the removed-frame count are 0, and the output carries no beats.
- R2: The register port uses these address codes. Code 0 is control, with bit 2 = broadcast drop, bit 1 = multicast match, bit 0 = unicast match, and its other bits read 0. Code 1 holds group address bits 31:0. Code 2 holds group address bits 47:32 in bits 15:0, and bits 31:16 read 0. Code 3 holds station address bits 31:0. Code 4 holds station address bits 47:32 in bits 15:0. Code 5 returns the removed-frame count. Registers at codes 0 to 4 read back what was written.
- R3: The first destination byte received is compared with address bits 47:40, and the sixth with bits 7:0. The verdict uses the control bits, the addresses and the VLAN flag as they stand on the cycle the sixth byte is accepted.
- R4: An all-ones destination is broadcast. It is rejected when broadcast drop is 1 and passed when that bit is 0.
- R5: A destination whose first byte has bit 0 set and which is not broadcast is multicast. With multicast match at 1, it passes only if it equals the group address. With multicast match at 0, it always passes.
- R6: A destination whose first byte has bit 0 clear is unicast. With unicast match at 1, it passes only if it equals the station address, unless the VLAN flag is high, in which case it passes. With unicast match at 0, it always passes.
- R7: A frame that ends before its sixth byte is never rejected.
- R8: A rejected frame of at most STD_MAX bytes is removed entirely when drop_en is high on its last byte, and it increments the removed-frame count.
- R9: A rejected frame of at most STD_MAX bytes is forwarded whole when drop_en is low, with out_abort = 1 on its last byte, and the count does not change.
- R10: A rejected frame longer than STD_MAX bytes is forwarded whole with out_abort = 1 on its last byte, whatever drop_en is, and is not counted. Its first bytes leave the block before its last byte arrives.
- R11: Passed frames leave in arrival order, with their bytes unchanged and start and end marks preserved, and out_abort = 0. A frame of at most STD_MAX bytes starts to leave only after its last byte has been accepted.
- R12: The removed-frame count saturates at its maximum. A read at code 5 with cfg_re returns the count and clears it. A removal on that same cycle leaves the count at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_vlan | input | 1 | Frame carries a VLAN tag |
| drop_en | input | 1 | Allows removal of rejected standard-size frames |
| cfg_addr | input | 3 | Register address code |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_re | input | 1 | Register read strobe (clears the count at code 5) |
| cfg_rdata | output | 32 | Register read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of an output frame |
| out_eop | output | 1 | Last byte of an output frame |
| out_abort | output | 1 | Abort mark, meaningful with out_eop |

## Verification
The bench builds the block with STD_MAX = 24 and CNT_W = 3. A frame of thirty bytes then crosses into the long-frame path, so the cut-through release and the forced abort of long frames can be exercised in a short run. Nine removed frames are enough to drive the count into saturation, so the saturation limit and the clear-on-read collision can be reached without millions of frames. A behavioural model built on queues predicts every output beat, cycle by cycle. The bench checks back-to-back standard frames, frames shorter than an address, and frames carrying a VLAN tag.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef struct packed {
      logic       abort;
      logic       eop;
      logic       sop;
      logic [7:0] data;
   } rxf_beat_t;

   localparam int CTL_UC = 0;
   localparam int CTL_MC = 1;
   localparam int CTL_BC = 2;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_MC_LO = 3'd1,
      RA_MC_HI = 3'd2,
      RA_ST_LO = 3'd3,
      RA_ST_HI = 3'd4,
      RA_DROPS = 3'd5
   } rxf_reg_e;

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        valid,
   input  logic        sop,
   input  logic [7:0]  data,
   input  logic        vlan,
   input  logic [2:0]  ctl,
   input  logic [47:0] mc_addr,
   input  logic [47:0] st_addr,
   output logic        reject
);
   localparam int NBYTES = 6;

   logic [2:0]  idx_q, idx_eff;
   logic [39:0] hist_q;
   logic        rej_q, rej_eff, at_last, verdict;
   logic        is_bc, is_mc;
   logic [47:0] full;
   logic [NBYTES-1:0] mc_eq, st_eq;

   assign idx_eff = sop ? 3'd0 : idx_q;
   assign rej_eff = sop ? 1'b0 : rej_q;
   assign full    = {hist_q, data};
   assign at_last = valid && (idx_eff == 3'(NBYTES - 1));

   for (genvar b = 0; b < NBYTES; b++) begin : g_cmp
      assign mc_eq[b] = (full[8*b +: 8] == mc_addr[8*b +: 8]);
      assign st_eq[b] = (full[8*b +: 8] == st_addr[8*b +: 8]);
   end

   assign is_bc = &full;
   assign is_mc = full[40] & ~is_bc;

   always_comb begin
      if (is_bc)      verdict = ctl[CTL_BC];
      else if (is_mc) verdict = ctl[CTL_MC] & ~(&mc_eq);
      else            verdict = ctl[CTL_UC] & ~vlan & ~(&st_eq);
   end

   assign reject = at_last ? verdict : rej_eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         hist_q <= '0;
         rej_q  <= 1'b0;
      end else if (valid) begin
         idx_q <= (idx_eff == 3'(NBYTES)) ? 3'(NBYTES) : idx_eff + 3'd1;
         if (idx_eff < 3'(NBYTES - 1)) hist_q <= {hist_q[31:0], data};
         rej_q <= at_last ? verdict : rej_eff;
      end
   end

   p_short_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sop) |-> (idx_eff == 3'd0 && !reject));
endmodule

// File: rtl/rxf_frame_buf.sv
module rxf_frame_buf
   import rxf_pkg::*;
#(
   parameter int STD_MAX = 1518
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      valid,
   input  logic      sop,
   input  logic      eop,
   input  logic [7:0] data,
   input  logic      reject,
   input  logic      drop_en,
   output logic      drop_pulse,
   output logic      out_valid,
   output rxf_beat_t out_beat
);
   localparam int DEPTH = 1 << $clog2(STD_MAX + 4);
   localparam int AW    = $clog2(DEPTH);
   localparam int LW    = $clog2(STD_MAX + 2);
   localparam logic [LW-1:0] LEN_TOP = LW'(STD_MAX + 1);

   rxf_beat_t   mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, commit_ptr, start_q, start_eff, occ;
   logic [LW-1:0] len_q, len_eff, len_new;
   logic          long_now, drop_now, wr_en;
   rxf_beat_t     wbeat;

   assign len_eff   = sop ? '0 : len_q;
   assign len_new   = (len_eff == LEN_TOP) ? len_eff : len_eff + LW'(1);
   assign long_now  = (len_new > LW'(STD_MAX));
   assign start_eff = sop ? wr_ptr : start_q;
   assign drop_now  = valid && eop && !long_now && reject && drop_en;
   assign wr_en     = valid && !drop_now;
   assign wbeat     = '{abort: eop & reject, eop: eop, sop: sop, data: data};
   assign drop_pulse = drop_now;
   assign occ       = wr_ptr - rd_ptr;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wbeat;
      out_beat <= mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         commit_ptr <= '0;
         start_q    <= '0;
         len_q      <= '0;
         out_valid  <= 1'b0;
      end else begin
         if (valid) begin
            len_q   <= eop ? '0 : len_new;
            start_q <= start_eff;
         end
         if (drop_now) wr_ptr <= start_eff;
         else if (wr_en) begin
            wr_ptr <= wr_ptr + AW'(1);
            if (eop || long_now) commit_ptr <= wr_ptr + AW'(1);
         end
         out_valid <= (rd_ptr != commit_ptr);
         if (rd_ptr != commit_ptr) rd_ptr <= rd_ptr + AW'(1);
      end
   end

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= AW'(STD_MAX + 2));
   p_abort_on_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_beat.abort) |-> out_beat.eop);
endmodule

// File: rtl/rxf_drop_count.sv
module rxf_drop_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)              count <= '0;
      else if (clr)            count <= inc ? W'(1) : '0;
      else if (inc && count != TOP) count <= count + W'(1);
   end

   p_clear_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count <= W'(1)));
   p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP && !clr) |=> (count == TOP));
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
   import rxf_pkg::*;
#(
   parameter int STD_MAX = 1518,
   parameter int CNT_W   = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_sop,
   input  logic        in_eop,
   input  logic        in_vlan,
   input  logic        drop_en,
   input  logic [2:0]  cfg_addr,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   input  logic        cfg_re,
   output logic [31:0] cfg_rdata,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_sop,
   output logic        out_eop,
   output logic        out_abort
);
   if (STD_MAX < 8) begin : g_bad_std
      $error("STD_MAX must be at least 8");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   logic [2:0]  ctl_q;
   logic [47:0] mc_q, st_q;
   logic        reject, drop_pulse, cnt_clr;
   logic [CNT_W-1:0] cnt;
   logic [31:0] cnt_ext;
   rxf_beat_t   beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         mc_q  <= '0;
         st_q  <= '0;
      end else if (cfg_we) begin
         case (rxf_reg_e'(cfg_addr))
            RA_CTRL:  ctl_q        <= cfg_wdata[2:0];
            RA_MC_LO: mc_q[31:0]   <= cfg_wdata;
            RA_MC_HI: mc_q[47:32]  <= cfg_wdata[15:0];
            RA_ST_LO: st_q[31:0]   <= cfg_wdata;
            RA_ST_HI: st_q[47:32]  <= cfg_wdata[15:0];
            default: ;
         endcase
      end
   end

   if (CNT_W < 32) begin : g_cnt_pad
      assign cnt_ext = {{(32 - CNT_W){1'b0}}, cnt};
   end else begin : g_cnt_full
      assign cnt_ext = cnt;
   end

   always_comb begin
      case (rxf_reg_e'(cfg_addr))
         RA_CTRL:  cfg_rdata = {29'd0, ctl_q};
         RA_MC_LO: cfg_rdata = mc_q[31:0];
         RA_MC_HI: cfg_rdata = {16'd0, mc_q[47:32]};
         RA_ST_LO: cfg_rdata = st_q[31:0];
         RA_ST_HI: cfg_rdata = {16'd0, st_q[47:32]};
         RA_DROPS: cfg_rdata = cnt_ext;
         default:  cfg_rdata = '0;
      endcase
   end

   assign cnt_clr = cfg_re && (rxf_reg_e'(cfg_addr) == RA_DROPS);

   rxf_classify u_cls (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .sop(in_sop), .data(in_data),
      .vlan(in_vlan), .ctl(ctl_q), .mc_addr(mc_q), .st_addr(st_q), .reject(reject)
   );

   rxf_frame_buf #(.STD_MAX(STD_MAX)) u_buf (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .sop(in_sop), .eop(in_eop),
      .data(in_data), .reject(reject), .drop_en(drop_en), .drop_pulse(drop_pulse),
      .out_valid(out_valid), .out_beat(beat)
   );

   rxf_drop_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(drop_pulse), .clr(cnt_clr), .count(cnt)
   );

   assign out_data  = beat.data;
   assign out_sop   = beat.sop;
   assign out_eop   = beat.eop;
   assign out_abort = beat.abort;

   p_drop_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_pulse |-> (drop_en && in_eop && reject));
   p_count_moves_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!drop_pulse && !cnt_clr) |=> $stable(cnt));
endmodule

// File: tb/tb_rxf_addr_filter.sv
`timescale 1ns/1ps
module tb_rxf_addr_filter;
   localparam int STD = 24;
   localparam int CW  = 3;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, in_sop = 0, in_eop = 0, in_vlan = 0, drop_en = 0;
   logic [7:0] in_data = 0;
   logic [2:0] cfg_addr = 0;
   logic cfg_we = 0, cfg_re = 0;
   logic [31:0] cfg_wdata = 0, cfg_rdata;
   logic out_valid, out_sop, out_eop, out_abort;
   logic [7:0] out_data;

   int checks = 0, errors = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rxf_addr_filter #(.STD_MAX(STD), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .in_vlan(in_vlan), .drop_en(drop_en),
      .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_re(cfg_re),
      .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort)
   );

   // configuration as seen by the model
   bit [2:0]  m_ctl = 0;
   bit [47:0] m_mc = 0, m_st = 0;

   // behavioural reference model
   bit [10:0] cur[$];
   bit [10:0] ready[$];
   bit        exp_v = 0;
   bit [10:0] exp_b = 0;
   int        m_len = 0;
   bit [47:0] m_dst = 0;
   bit        m_rej = 0;

   function automatic bit judge(bit [47:0] d, bit vlan);
      if (d == 48'hFFFF_FFFF_FFFF) return m_ctl[2];
      if (d[40]) return m_ctl[1] && (d != m_mc);
      return m_ctl[0] && !vlan && (d != m_st);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         cur.delete(); ready.delete(); exp_v = 0; m_len = 0; m_rej = 0;
      end else begin
         exp_v = (ready.size() > 0);
         if (exp_v) exp_b = ready.pop_front();
         if (in_valid) begin
            bit [10:0] b;
            if (in_sop) begin cur.delete(); m_len = 0; m_rej = 0; end
            m_len++;
            if (m_len <= 6) m_dst = {m_dst[39:0], in_data};
            if (m_len == 6) m_rej = judge(m_dst, in_vlan);
            b = {1'b0, in_eop, in_sop, in_data};
            if (in_eop) b[10] = m_rej;
            if (m_len > STD) begin
               while (cur.size() > 0) ready.push_back(cur.pop_front());
               ready.push_back(b);
            end else if (in_eop) begin
               if (m_rej && drop_en) cur.delete();
               else begin
                  cur.push_back(b);
                  while (cur.size() > 0) ready.push_back(cur.pop_front());
               end
            end else cur.push_back(b);
         end
      end
   end

   // per-cycle stream comparison
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_valid !== exp_v ||
             (exp_v && {out_abort, out_eop, out_sop, out_data} !== exp_b)) begin
            errors++;
            $display("FAIL %s stream: got v=%0b beat=%h, expected v=%0b beat=%h",
                     cur_req, out_valid, {out_abort, out_eop, out_sop, out_data},
                     exp_v, exp_b);
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h, expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); cfg_re = 1; cfg_addr = a; #1;
      check(cfg_rdata === exp, req, cfg_rdata, exp);
      @(negedge clk); cfg_re = 0;
   endtask

   task automatic set_ctl(input bit [2:0] c);
      m_ctl = c; wr(3'd0, {29'd0, c});
   endtask

   task automatic send(input logic [47:0] dst, input int len, input bit vlan,
                       input bit de, input bit rd_at_end);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1; in_sop = (i == 0); in_eop = (i == len - 1);
         in_vlan = vlan; drop_en = de;
         in_data = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i * 7 + 3);
         if (rd_at_end && i == len - 1) begin cfg_re = 1; cfg_addr = 3'd5; end
      end
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0; cfg_re = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MC  = 48'h0100_5E12_3407;
   localparam logic [47:0] MCX = 48'h0100_5E12_3408;
   localparam logic [47:0] ST  = 48'h0211_2233_4455;
   localparam logic [47:0] STX = 48'h0211_2233_4456;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      cur_req = "R1";
      #1 check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
      rd_chk(3'd0, 0, "R1 ctrl");
      rd_chk(3'd1, 0, "R1 group low");
      rd_chk(3'd5, 0, "R1 count");
      // R2 register map
      cur_req = "R2";
      wr(3'd1, MC[31:0]); wr(3'd2, 32'hFFFF_0000 | MC[47:32]);
      wr(3'd3, ST[31:0]); wr(3'd4, {16'd0, ST[47:32]});
      m_mc = MC; m_st = ST;
      wr(3'd0, 32'hFFFF_FFF8);
      rd_chk(3'd0, 0, "R2 ctrl spare bits");
      rd_chk(3'd1, MC[31:0], "R2 group low");
      rd_chk(3'd2, {16'd0, MC[47:32]}, "R2 group high reserved");
      rd_chk(3'd3, ST[31:0], "R2 station low");
      rd_chk(3'd4, {16'd0, ST[47:32]}, "R2 station high");
      // R11 everything passes with filters off, back to back
      cur_req = "R11";
      set_ctl(3'b000);
      send(BC, 10, 0, 1, 0); send(MCX, 12, 0, 1, 0); send(STX, 8, 0, 1, 0);
      idle(40);
      rd_chk(3'd5, 0, "R11 nothing removed");
      // R4 broadcast drop, R8 removal and count
      cur_req = "R4";
      set_ctl(3'b100);
      send(BC, 12, 0, 1, 0); send(ST, 9, 0, 1, 0);
      idle(40);
      rd_chk(3'd5, 1, "R8 one broadcast removed");
      // R5 multicast match, R3 byte order
      cur_req = "R5";
      set_ctl(3'b010);
      send(MC, 14, 0, 1, 0); send(MCX, 14, 0, 1, 0); send(BC, 8, 0, 1, 0);
      idle(40);
      rd_chk(3'd5, 1, "R5 one group mismatch removed");
      // R6 unicast match and VLAN bypass
      cur_req = "R6";
      set_ctl(3'b001);
      send(ST, 10, 0, 1, 0); send(STX, 10, 0, 1, 0); send(STX, 10, 1, 1, 0);
      send(MCX, 10, 0, 1, 0);
      idle(40);
      rd_chk(3'd5, 1, "R6 one station mismatch removed");
      // R7 short frame never rejected
      cur_req = "R7";
      set_ctl(3'b111);
      send(BC, 4, 0, 1, 0); send(STX, 1, 0, 1, 0);
      idle(20);
      rd_chk(3'd5, 0, "R7 short frames kept");
      // R9 rejected but drop disabled
      cur_req = "R9";
      send(BC, 16, 0, 0, 0); send(STX, STD, 0, 0, 0);
      idle(50);
      rd_chk(3'd5, 0, "R9 abort not counted");
      // R10 long rejected frame: cut-through with abort
      cur_req = "R10";
      send(BC, STD + 6, 0, 1, 0); send(ST, STD + 1, 0, 1, 0); send(STX, STD, 0, 1, 0);
      idle(60);
      rd_chk(3'd5, 1, "R10 only the standard frame counted");
      // R12 saturation and read collision
      cur_req = "R12";
      for (int k = 0; k < 9; k++) send(BC, 8, 0, 1, 0);
      idle(10);
      rd_chk(3'd5, 7, "R12 saturated");
      rd_chk(3'd5, 0, "R12 cleared by read");
      send(BC, 8, 0, 1, 1);
      idle(5);
      rd_chk(3'd5, 1, "R12 removal on read cycle kept");
      idle(20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule